// File: doc/BRIEF.md
# E1 Transmit Error Injector

This block sits at the end of the transmit path of an E1 framer. It receives the outgoing 2.048 Mb/s bit stream one bit per clock, together with a frame-start marker and a multiframe-start marker. From these it tracks the bit (1 to 8), timeslot (0 to 31) and frame (0 to 15) of every bit. On command it damages chosen positions of the stream, then encodes the result as HDB3 on a positive and a negative rail for the line driver.

Software arms the error types through one control register. Most types are one-shot: a 0-to-1 change of the enable bit arms one corruption, and that corruption lands on the first position that fits the type. The loss-of-signal bit is different. It blanks the line for as long as it is held high. Corruption happens before encoding, so the encoder still gives a valid HDB3 stream around a damaged bit. The one exception is the bipolar-violation error, which is applied at the polarity stage.

Top module: `e1ErrInjector`

## Requirements
- R1: A write on `regWrEn` stores `regWrData` in the control register. `regRdData` shows it from the next cycle. The register fields are: bit0 bipolar violation, bit1 CRC-4, bit2 FAS, bit3 NFAS, bit4 payload, bit5 E-bit, bit6 loss of signal.
- R2: `frameSync` marks bit 1 of timeslot 0. `mfSync` with `frameSync` marks frame 0. Bit, timeslot and frame count on from those marks. No corruption is applied before the first multiframe mark, and a request armed earlier waits for it.
- R3: A CRC-4 request inverts bit 1 of timeslot 0 in the next even frame.
- R4: An E-bit request forces bit 1 of timeslot 0 to 0 in the next frame 13 or 15.
- R5: An FAS request inverts bit 2 of timeslot 0 in the next even frame.
- R6: An NFAS request inverts bit 2 of timeslot 0 in the next odd frame.
- R7: A payload request inverts the next bit that lies in timeslots 1 to 31.
- R8: Each one-shot request arms only on a 0-to-1 change of its bit and fires once. Writing 1 to a bit that is already 1 arms nothing.
- R9: The line output is HDB3 with a latency of 4 clocks. Ordinary marks alternate in polarity. Each run of four zeros becomes 000V when an odd number of pulses has been sent since the last V, and B00V when that number is even. B takes the polarity opposite to the previous pulse, and V takes the same polarity. After reset the first pulse is positive.
- R10: A bipolar-violation request makes the next ordinary mark that reaches the line take the same polarity as the previous pulse.
- R11: While the loss-of-signal bit is 1, both rails stay at 0 from the second clock after the write. The encoder keeps running underneath.
- R12: After reset both rails and the control register are 0. The two rails are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| dataIn | input | 1 | Transmit bit before corruption |
| frameSync | input | 1 | High on bit 1 of timeslot 0 |
| mfSync | input | 1 | High with frameSync on frame 0 of the multiframe |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | REG_W | Control register write value |
| regRdData | output | REG_W | Control register contents |
| linePos | output | 1 | Positive HDB3 rail |
| lineNeg | output | 1 | Negative HDB3 rail |

## Verification
The bench builds the block with its default parameters: 8-bit timeslots, 32 timeslots and a 16-frame multiframe. Frames 13 and 15 of three successive multiframes therefore fall within about 12,000 cycles. Each output cycle is compared with an arithmetic model of position, corruption, HDB3 substitution and polarity. The stimulus includes sparse-data stretches, so both the 000V and the B00V forms appear many times. A violation request is armed while loss of signal hides the line, which shows that the encoder state keeps advancing under the blanking.

// File: rtl/e1InjPkg.sv
package e1InjPkg;

  // control register field positions
  localparam int FLD_BPV  = 0;
  localparam int FLD_CRC  = 1;
  localparam int FLD_FAS  = 2;
  localparam int FLD_NFAS = 3;
  localparam int FLD_PAY  = 4;
  localparam int FLD_EBIT = 5;
  localparam int FLD_LOS  = 6;
  localparam int NUM_SHOT = 6;

  // strobes from control to datapath for the bit entering this cycle
  typedef struct packed {
    logic flip;      // invert the entering bit
    logic clear;     // force the entering bit to zero
    logic bpvArmed;  // a polarity violation is waiting for a mark
    logic losOn;     // blank both rails
  } injStrobeT;

  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_MARK  = 2'd1,
    SYM_BIP   = 2'd2,
    SYM_VIOL  = 2'd3
  } symT;

endpackage

// File: rtl/e1InjCtrl.sv
module e1InjCtrl
  import e1InjPkg::*;
#(
  parameter int TS_BITS   = 8,
  parameter int NUM_TS    = 32,
  parameter int MF_FRAMES = 16,
  parameter int REG_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameSync,
  input  logic             mfSync,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             bpvFired,
  output injStrobeT        strobe
);

  localparam int BIT_W = $clog2(TS_BITS);
  localparam int TS_W  = $clog2(NUM_TS);
  localparam int FRM_W = $clog2(MF_FRAMES);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TS_BITS - 1);
  localparam logic [TS_W-1:0]  TS_LAST  = TS_W'(NUM_TS - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(MF_FRAMES - 1);
  localparam logic [FRM_W-1:0] FRM_E1   = FRM_W'(MF_FRAMES - 3);

  logic [REG_W-1:0] regQ;
  logic [BIT_W-1:0] bitQ, curBit;
  logic [TS_W-1:0]  tsQ, curTs;
  logic [FRM_W-1:0] frmQ, curFrm, nextFrm;
  logic             locked, posValid;
  logic [NUM_SHOT-1:0] pend, pendNext, fire, arm;
  logic crcPos, fasPos, nfasPos, payPos, ebitPos;

  // position of the bit entering this cycle
  assign nextFrm = (frmQ == FRM_LAST) ? '0 : frmQ + 1'b1;

  always_comb begin
    curBit = bitQ;
    curTs  = tsQ;
    curFrm = frmQ;
    if (frameSync) begin
      curBit = '0;
      curTs  = '0;
      curFrm = mfSync ? '0 : nextFrm;
    end else if (bitQ == BIT_LAST) begin
      curBit = '0;
      if (tsQ == TS_LAST) begin
        curTs  = '0;
        curFrm = nextFrm;
      end else begin
        curTs = tsQ + 1'b1;
      end
    end else begin
      curBit = bitQ + 1'b1;
    end
  end

  assign posValid = locked | (frameSync & mfSync);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitQ   <= '0;
      tsQ    <= '0;
      frmQ   <= '0;
      locked <= 1'b0;
    end else begin
      bitQ   <= curBit;
      tsQ    <= curTs;
      frmQ   <= curFrm;
      locked <= posValid;
    end
  end

  // eligible positions per error class
  assign crcPos  = (curTs == '0) && (curBit == '0) && !curFrm[0];
  assign ebitPos = (curTs == '0) && (curBit == '0) &&
                   ((curFrm == FRM_E1) || (curFrm == FRM_LAST));
  assign fasPos  = (curTs == '0) && (curBit == BIT_W'(1)) && !curFrm[0];
  assign nfasPos = (curTs == '0) && (curBit == BIT_W'(1)) && curFrm[0];
  assign payPos  = (curTs != '0);

  // one-shot request slots
  for (genvar i = 0; i < NUM_SHOT; i++) begin : gShot
    if (i == FLD_BPV) begin : gLine
      assign fire[i] = pend[i] & bpvFired;
    end else begin : gPos
      logic hit;
      assign hit = (i == FLD_CRC)  ? crcPos  :
                   (i == FLD_FAS)  ? fasPos  :
                   (i == FLD_NFAS) ? nfasPos :
                   (i == FLD_PAY)  ? payPos  : ebitPos;
      assign fire[i] = pend[i] & posValid & hit;
    end
    assign arm[i]      = regWrEn & regWrData[i] & ~regQ[i];
    assign pendNext[i] = (pend[i] & ~fire[i]) | arm[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      regQ <= '0;
    end else begin
      pend <= pendNext;
      if (regWrEn) regQ <= regWrData;
    end
  end

  assign regRdData       = regQ;
  assign strobe.flip     = fire[FLD_CRC] | fire[FLD_FAS] | fire[FLD_NFAS] | fire[FLD_PAY];
  assign strobe.clear    = fire[FLD_EBIT];
  assign strobe.bpvArmed = pend[FLD_BPV];
  assign strobe.losOn    = regQ[FLD_LOS];

endmodule

// File: rtl/e1InjDatapath.sv
module e1InjDatapath
  import e1InjPkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dataIn,
  input  injStrobeT strobe,
  output logic      linePos,
  output logic      lineNeg,
  output logic      bpvFired
);

  localparam int RUN = 4;  // zero run length replaced by the line code

  symT  pipe [RUN];
  logic [RUN-2:0] idle;
  logic txBit, subst, parity, lastPol, pulse, pol;

  // corruption of the entering bit
  assign txBit = strobe.clear ? 1'b0 : (dataIn ^ strobe.flip);

  for (genvar i = 1; i < RUN; i++) begin : gIdle
    assign idle[i-1] = (pipe[i] == SYM_SPACE);
  end

  assign subst = !txBit && (&idle);

  // look-ahead window: pipe[RUN-1] newest, pipe[0] leaves next
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RUN; i++) pipe[i] <= SYM_SPACE;
      parity <= 1'b0;
    end else begin
      pipe[RUN-1] <= txBit ? SYM_MARK : (subst ? SYM_VIOL : SYM_SPACE);
      for (int i = 1; i < RUN - 1; i++) pipe[i] <= pipe[i+1];
      pipe[0] <= (subst && !parity) ? SYM_BIP : pipe[1];
      parity  <= txBit ? ~parity : (subst ? 1'b0 : parity);
    end
  end

  // polarity stage
  assign bpvFired = strobe.bpvArmed && (pipe[0] == SYM_MARK);
  assign pulse    = (pipe[0] != SYM_SPACE);

  always_comb begin
    unique case (pipe[0])
      SYM_VIOL: pol = lastPol;
      SYM_MARK: pol = bpvFired ? lastPol : ~lastPol;
      default:  pol = ~lastPol;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastPol <= 1'b0;
      linePos <= 1'b0;
      lineNeg <= 1'b0;
    end else begin
      if (pulse) lastPol <= pol;
      linePos <= !strobe.losOn && pulse && pol;
      lineNeg <= !strobe.losOn && pulse && !pol;
    end
  end

endmodule

// File: rtl/e1ErrInjector.sv
module e1ErrInjector
  import e1InjPkg::*;
#(
  parameter int TS_BITS   = 8,
  parameter int NUM_TS    = 32,
  parameter int MF_FRAMES = 16,
  parameter int REG_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dataIn,
  input  logic             frameSync,
  input  logic             mfSync,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             linePos,
  output logic             lineNeg
);

  injStrobeT strobe;
  logic      bpvFired;

  e1InjCtrl #(
    .TS_BITS  (TS_BITS),
    .NUM_TS   (NUM_TS),
    .MF_FRAMES(MF_FRAMES),
    .REG_W    (REG_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .frameSync(frameSync),
    .mfSync   (mfSync),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .bpvFired (bpvFired),
    .strobe   (strobe)
  );

  e1InjDatapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .dataIn  (dataIn),
    .strobe  (strobe),
    .linePos (linePos),
    .lineNeg (lineNeg),
    .bpvFired(bpvFired)
  );

endmodule

// File: rtl/e1InjChecker.sv
module e1InjChecker
  import e1InjPkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             linePos,
  input logic             lineNeg
);

  logic       losQ;
  logic [2:0] zeroRun;
  logic [3:0] settle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      losQ    <= 1'b0;
      zeroRun <= '0;
      settle  <= '0;
    end else begin
      losQ <= regRdData[FLD_LOS];
      if (settle != 4'd15) settle <= settle + 4'd1;
      if (linePos || lineNeg || regRdData[FLD_LOS] || losQ || (settle < 4'd8))
        zeroRun <= '0;
      else if (zeroRun != 3'd7)
        zeroRun <= zeroRun + 3'd1;
    end
  end

  AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> (regRdData == $past(regWrData))) else $error("AST_REG_WRITE"); // R1

  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (settle >= 4'd8) |-> (zeroRun <= 3'd3)) else $error("AST_ZERO_RUN"); // R9

  AST_LOS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(regRdData[FLD_LOS]) |-> (!linePos && !lineNeg)) else $error("AST_LOS_QUIET"); // R11

  AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(linePos && lineNeg)) else $error("AST_RAILS_EXCL"); // R12

endmodule

bind e1ErrInjector e1InjChecker #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .linePos  (linePos),
  .lineNeg  (lineNeg)
);

// File: tb/e1ErrInjector_tb.sv
module e1ErrInjector_tb;

  localparam int N  = 12352;
  localparam int S  = 8;      // first multiframe mark
  localparam int FB = 256;    // bits per frame
  localparam int MB = 4096;   // bits per multiframe

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, dataIn, frameSync, mfSync, regWrEn;
  logic [7:0] regWrData, regRdData;
  logic       linePos, lineNeg;

  e1ErrInjector u_dut (
    .clk(clk), .rst_n(rst_n), .dataIn(dataIn), .frameSync(frameSync),
    .mfSync(mfSync), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .linePos(linePos), .lineNeg(lineNeg)
  );

  bit         inBit [N];
  bit         wrA   [N];
  logic [7:0] wdA   [N];
  logic [1:0] expR  [N];
  string      tagA  [N];
  int         kind  [N+4];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int n, input logic [7:0] v);
    wrA[n] = 1'b1;
    wdA[n] = v;
  endtask

  task automatic buildStim();
    logic [15:0] lfsr = 16'hACE1;
    for (int n = 0; n < N; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if ((n >= 5000 && n < 6000) || (n >= 10000 && n < 11000))
        inBit[n] = (n % 9 == 0);
      else
        inBit[n] = lfsr[0];
      wrA[n] = 1'b0;
      wdA[n] = 8'h00;
      tagA[n] = "R9";
    end
    wr(2, 8'h10);                   // payload armed before sync: R2, R7
    wr(300, 8'h00); wr(310, 8'h04); // FAS: R5
    wr(600, 8'h0C);                 // NFAS rises, FAS held: R6, R8
    wr(900, 8'h00); wr(910, 8'h02); // CRC: R3
    wr(1200, 8'h00); wr(1210, 8'h20); // E-bit: R4
    wr(3600, 8'h00); wr(3610, 8'h01); // violation: R10
    wr(4000, 8'h00); wr(4010, 8'h40); // loss of signal: R11
    wr(4300, 8'h00); wr(4400, 8'h3F); // all one-shots together
    wr(6000, 8'h00); wr(6010, 8'h20);
    wr(8000, 8'h00); wr(8010, 8'h12);
    wr(8500, 8'h00); wr(9000, 8'h40); wr(9001, 8'h41); // violation under blanking
    wr(9200, 8'h00); wr(9300, 8'h20);
  endtask

  task automatic buildModel();
    logic [7:0] regM = 8'h00;
    bit pend [6];
    bit par = 1'b0, lastPol = 1'b0;
    for (int i = 0; i < 6; i++) pend[i] = 1'b0;
    for (int k = 0; k < N + 4; k++) kind[k] = 0;
    for (int e = 0; e < N; e++) begin
      int k = kind[e];
      bit pol = 1'b0, c, flip = 1'b0, clr = 1'b0;
      string t = "";
      // polarity stage on symbol e
      if (k == 1) begin
        if (pend[0]) begin pol = lastPol; pend[0] = 1'b0; tagA[e] = "R10"; end
        else pol = !lastPol;
      end else if (k == 2) pol = !lastPol;
      else if (k == 3) pol = lastPol;
      if (k != 0) lastPol = pol;
      if (regM[6]) begin expR[e] = 2'b00; tagA[e] = "R11"; end
      else expR[e] = (k == 0) ? 2'b00 : (pol ? 2'b10 : 2'b01);
      // corruption of input bit e
      c = inBit[e];
      if (e >= S) begin
        int rel = e - S;
        int b = rel % 8, ts = (rel / 8) % 32, fr = (rel / FB) % 16;
        if (pend[1] && ts == 0 && b == 0 && fr % 2 == 0) begin flip = 1; pend[1] = 0; t = "R3"; end
        if (pend[5] && ts == 0 && b == 0 && (fr == 13 || fr == 15)) begin clr = 1; pend[5] = 0; t = "R4"; end
        if (pend[2] && ts == 0 && b == 1 && fr % 2 == 0) begin flip = 1; pend[2] = 0; t = "R5"; end
        if (pend[3] && ts == 0 && b == 1 && fr % 2 == 1) begin flip = 1; pend[3] = 0; t = "R6"; end
        if (pend[4] && ts != 0) begin flip = 1; pend[4] = 0; t = (e < 300) ? "R2" : "R7"; end
      end
      c = clr ? 1'b0 : (c ^ flip);
      if (t != "" && e + 4 < N) tagA[e+4] = t;
      // line code on symbol e+4
      if (c) begin kind[e+4] = 1; par = !par; end
      else if (kind[e+3] == 0 && kind[e+2] == 0 && kind[e+1] == 0) begin
        kind[e+4] = 3;
        if (!par) kind[e+1] = 2;
        par = 1'b0;
      end else kind[e+4] = 0;
      // register write at this edge
      if (wrA[e]) begin
        for (int i = 0; i < 6; i++) if (wdA[e][i] && !regM[i]) pend[i] = 1'b1;
        regM = wdA[e];
      end
    end
    tagA[S + 4*FB + 1 + 4] = "R8";  // FAS held high must not fire again
    tagA[S + 5] = "R2";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    buildStim();
    buildModel();
    rst_n = 1'b0; dataIn = 1'b0; frameSync = 1'b0; mfSync = 1'b0;
    regWrEn = 1'b0; regWrData = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({linePos, lineNeg} == 2'b00, "R12", "rails in reset", {linePos, lineNeg}, 0);
    chk(regRdData == 8'h00, "R12", "register in reset", regRdData, 0);
    rst_n = 1'b1;
    for (int n = 0; n < N; n++) begin
      dataIn    = inBit[n];
      frameSync = (n >= S) && ((n - S) % FB == 0);
      mfSync    = (n >= S) && ((n - S) % MB == 0);
      regWrEn   = wrA[n];
      regWrData = wdA[n];
      @(posedge clk);
      @(negedge clk);
      chk({linePos, lineNeg} == expR[n], tagA[n], $sformatf("rails after edge %0d", n),
          {linePos, lineNeg}, expR[n]);
      chk(!(linePos && lineNeg), "R12", "both rails high", {linePos, lineNeg}, 0);
      if (wrA[n])
        chk(regRdData == wdA[n], "R1", "register readback", regRdData, wdA[n]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule